// File: doc/BRIEF.md
# Edge-Interval Telemetry Bit Recovery

This block turns the return pulses from a motor controller into a 21-bit telemetry word. The pulses arrive on a shared line after an outgoing DShot command frame. Once the host has finished transmitting, it pulses `start_i`, and a receive window opens. The window lasts `timeout_i` timer ticks. Inside the window, every filtered transition of `line_i` gets a timestamp from a free-running tick counter. Both rising and falling transitions count. The counter runs at 16 ticks per telemetry bit.

The block does not sample each bit cell. Instead it rounds the tick distance between consecutive edges to a whole number of bits. Each such run goes into the word as a one followed by zeros. When the window closes, any shortfall is filled with a final padding run, so a well-formed frame always has exactly 21 bits. A frame that overshoots 21 bits, or one that has no edges at all, is reported as an error. Decoding the GCR symbols and moving the result elsewhere are left to the blocks downstream.

Top module: `telem_edge_rx`

## Requirements
- R1: After reset, `valid_o` and `err_o` are 0 and `word_o` is 0.
- R2: A change on `line_i` counts as an edge only after the new level has been sampled on FILT_LEN (4) consecutive clock edges. Changes in either direction count. A level held for 3 cycles or fewer produces no edge.
- R3: A tick lasts TICK_DIV (2) clock cycles. The run length between two accepted edges is (tick distance + 8) / 16, using integer division.
- R4: Each run of length L>0 appends L bits to the word, most significant first: a 1 followed by L-1 zeros. A run that rounds to 0 appends nothing. In the reported word, bit 20 is the first bit received.
- R5: The first accepted edge of a window appends nothing. It only serves as the reference for the next run.
- R6: Once the accumulated bit count reaches 21 or more, later edges in the window are not consumed.
- R7: When the window closes with at least one edge accepted and fewer than 21 bits accumulated, a final run of length (21 - count) is appended. A single edge therefore yields 0x100000.
- R8: A window that closes with no edge accepted, or with more than 21 bits, gives an `err_o` pulse and leaves `word_o` unchanged. `valid_o` and `err_o` are never high together.
- R9: If `start_i` is high in cycle 0, the window closes once the tick count since start reaches `timeout_i`. The result pulse (`valid_o` with the new `word_o`, or `err_o`) is high in cycle TICK_DIV*T+2 and in no other cycle.
- R10: If `start_i` is high in cycle 0, a line change made in cycle c is consumed when c <= TICK_DIV*T-4. That includes an edge that lands in the closing cycle, which is consumed before padding. A later change is ignored.
- R11: At most MAX_EDGES (32) edges are accepted per window. Further edges are ignored.
- R12: A `start_i` pulse during an open window is ignored. The window keeps its original closing time and gives a single result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse marking the end of the outgoing frame; opens the window |
| line_i | input | 1 | Synchronized telemetry return line |
| timeout_i | input | CNT_W | Window length in ticks |
| word_o | output | WORD_BITS | Last good 21-bit telemetry word |
| valid_o | output | 1 | One-cycle pulse: word_o holds a new good frame |
| err_o | output | 1 | One-cycle pulse: frame rejected |

## Verification
Two events can fall on the same clock edge: consuming the last edge of a frame and closing the window. When they coincide, the edge's run must be folded in before the padding run is computed. The bench uses a 100-tick window and places a transition at cycle 196, whose timestamp is taken exactly at the closing edge. The expected word holds a 5-bit run followed by 16 bits of padding. The same stimulus shifted one cycle later must give a single padding run of 21 bits. Together these two checks pin down the exact boundary between consuming an edge and padding.

// File: rtl/telem_rx_pkg.sv
package telem_rx_pkg;
  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_CAPTURE = 1'b1
  } rx_state_e;
endpackage

// File: rtl/telem_edge_filter.sv
// Accepts a level change only after FILT_LEN identical samples; emits a
// one-cycle pulse on every accepted change of either direction.
module telem_edge_filter #(
  parameter int   FILT_LEN   = 4,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic edge_o
);
  logic [FILT_LEN-1:0] hist_q;
  logic                level_q;
  logic                flip;

  assign flip = (hist_q == {FILT_LEN{~level_q}});

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= {FILT_LEN{IDLE_LEVEL}};
      level_q <= IDLE_LEVEL;
      edge_o  <= 1'b0;
    end else begin
      hist_q <= {hist_q[FILT_LEN-2:0], line_i};
      edge_o <= flip;
      if (flip) level_q <= ~level_q;
    end
  end
endmodule

// File: rtl/telem_tick_timer.sv
// Free-running tick counter, cleared when a window opens.
module telem_tick_timer #(
  parameter int TICK_DIV = 2,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  output logic [CNT_W-1:0] stamp_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic tick_en;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [PW-1:0] presc_q;
      always_ff @(posedge clk) begin
        if (rst || clear_i) presc_q <= '0;
        else if (presc_q == PW'(TICK_DIV - 1)) presc_q <= '0;
        else presc_q <= presc_q + 1'b1;
      end
      assign tick_en = (presc_q == PW'(TICK_DIV - 1));
    end else begin : g_nodiv
      assign tick_en = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear_i) stamp_o <= '0;
    else if (tick_en)   stamp_o <= stamp_o + 1'b1;
  end
endmodule

// File: rtl/telem_run_packer.sv
// Appends one run (a 1 then len-1 zeros) to the word; saturating bit count.
module telem_run_packer #(
  parameter int WB = 21,
  parameter int LW = 13,
  localparam int BW = $clog2(WB + 2)
) (
  input  logic [WB-1:0] word_i,
  input  logic [BW-1:0] bits_i,
  input  logic [LW-1:0] len_i,
  output logic [WB-1:0] word_o,
  output logic [BW-1:0] bits_o
);
  localparam logic [WB-1:0] ONE = WB'(1);

  int sum_w;

  always_comb begin
    word_o = word_i;
    bits_o = bits_i;
    sum_w  = 0;
    if (len_i != '0) begin
      if (int'(len_i) > WB) begin
        word_o = '0;
        bits_o = BW'(WB + 1);
      end else begin
        word_o = (word_i << len_i) | (ONE << (len_i - 1'b1));
        sum_w  = int'(bits_i) + int'(len_i);
        bits_o = (sum_w > WB) ? BW'(WB + 1) : BW'(sum_w);
      end
    end
  end
endmodule

// File: rtl/telem_edge_rx.sv
module telem_edge_rx
  import telem_rx_pkg::*;
#(
  parameter int   TICKS_PER_BIT = 16,
  parameter int   TICK_DIV      = 2,
  parameter int   WORD_BITS     = 21,
  parameter int   MAX_EDGES     = 32,
  parameter int   FILT_LEN      = 4,
  parameter int   CNT_W         = 16,
  parameter logic IDLE_LEVEL    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 line_i,
  input  logic [CNT_W-1:0]     timeout_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 valid_o,
  output logic                 err_o
);
  localparam int SHIFT = $clog2(TICKS_PER_BIT);
  localparam int LW    = CNT_W + 1 - SHIFT;
  localparam int BW    = $clog2(WORD_BITS + 2);
  localparam int EW    = $clog2(MAX_EDGES + 1);

  rx_state_e            state_q;
  logic [CNT_W-1:0]     prev_q, stamp, diff;
  logic [EW-1:0]        ecnt_q, ecnt_n;
  logic [BW-1:0]        bits_q, bits_n, bits_f;
  logic [WORD_BITS-1:0] acc_q, acc_n, acc_f;
  logic [CNT_W:0]       rnd_sum;
  logic [LW-1:0]        run_len, pad_len;
  logic                 edge_p, capt, take, close, final_ok, open_win;

  telem_edge_filter #(.FILT_LEN(FILT_LEN), .IDLE_LEVEL(IDLE_LEVEL)) u_filt (
    .clk(clk), .rst(rst), .line_i(line_i), .edge_o(edge_p));

  assign capt     = (state_q == ST_CAPTURE);
  assign open_win = (state_q == ST_IDLE) && start_i;

  telem_tick_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .clear_i(open_win), .stamp_o(stamp));

  // Edge consumption: limited by edge budget and by a full word.
  assign take    = capt && edge_p && (ecnt_q < EW'(MAX_EDGES)) &&
                   (bits_q < BW'(WORD_BITS));
  assign diff    = stamp - prev_q;
  assign rnd_sum = {1'b0, diff} + (CNT_W + 1)'(TICKS_PER_BIT / 2);
  assign run_len = (take && ecnt_q != '0) ? rnd_sum[CNT_W:SHIFT] : '0;
  assign ecnt_n  = take ? ecnt_q + 1'b1 : ecnt_q;

  telem_run_packer #(.WB(WORD_BITS), .LW(LW)) u_run (
    .word_i(acc_q), .bits_i(bits_q), .len_i(run_len),
    .word_o(acc_n), .bits_o(bits_n));

  // Padding run uses the post-edge state so a closing-cycle edge counts.
  assign pad_len = (bits_n < BW'(WORD_BITS)) ?
                   (LW'(WORD_BITS) - LW'(bits_n)) : '0;

  telem_run_packer #(.WB(WORD_BITS), .LW(LW)) u_pad (
    .word_i(acc_n), .bits_i(bits_n), .len_i(pad_len),
    .word_o(acc_f), .bits_o(bits_f));

  assign close    = capt && (stamp >= timeout_i);
  assign final_ok = (ecnt_n != '0) && (bits_f == BW'(WORD_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      prev_q  <= '0;
      ecnt_q  <= '0;
      bits_q  <= '0;
      acc_q   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_CAPTURE;
            ecnt_q  <= '0;
            bits_q  <= '0;
            acc_q   <= '0;
          end
        end
        default: begin
          if (take) begin
            prev_q <= stamp;
            acc_q  <= acc_n;
            bits_q <= bits_n;
            ecnt_q <= ecnt_n;
          end
          if (close) begin
            state_q <= ST_IDLE;
            if (final_ok) begin
              valid_o <= 1'b1;
              word_o  <= acc_f;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/telem_edge_rx_chk.sv
module telem_edge_rx_chk
  import telem_rx_pkg::*;
#(
  parameter int WORD_BITS = 21,
  parameter int BW        = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start_i,
  input logic                 valid_o,
  input logic                 err_o,
  input logic [WORD_BITS-1:0] word_o,
  input rx_state_e            state_q,
  input logic [BW-1:0]        bits_q
);
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst) !(valid_o && err_o)); // R8
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst) !valid_o |-> $stable(word_o)); // R8
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst) (valid_o || err_o) |=> !(valid_o || err_o)); // R9
  AST_RESULT_ON_CLOSE: assert property (@(posedge clk) disable iff (rst) (valid_o || err_o) |-> (state_q == ST_IDLE && $past(state_q) == ST_CAPTURE)); // R9
  AST_LEADING_ONE: assert property (@(posedge clk) disable iff (rst) valid_o |-> word_o[WORD_BITS-1]); // R4
  AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (rst) (state_q == ST_CAPTURE && bits_q >= BW'(WORD_BITS)) |=> $stable(bits_q)); // R6
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst) (state_q == ST_CAPTURE && start_i) |=> (state_q == ST_CAPTURE || valid_o || err_o)); // R12
endmodule

bind telem_edge_rx telem_edge_rx_chk #(.WORD_BITS(WORD_BITS), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .valid_o(valid_o), .err_o(err_o),
  .word_o(word_o), .state_q(state_q), .bits_q(bits_q));

// File: tb/telem_edge_rx_test.sv
`timescale 1ns/1ps
module telem_edge_rx_test;
  localparam int NV = 8;
  // Intervals between successive edges, in ticks (1 tick = 2 clocks).
  localparam int VN [NV] = '{3, 4, 3, 2, 3, 3, 4, 2};
  localparam int VG [NV][8] = '{
    '{16, 32, 48, 0, 0, 0, 0, 0},   // R3 R4 R7: runs 1,2,3 then padding
    '{80, 80, 80, 96, 0, 0, 0, 0},  // R4: exactly 21 bits, no padding
    '{71, 56, 16, 0, 0, 0, 0, 0},   // R3: rounding down and up to 4
    '{160, 192, 0, 0, 0, 0, 0, 0},  // R8: 22 bits -> error
    '{160, 176, 32, 0, 0, 0, 0, 0}, // R6: third edge after full word ignored
    '{48, 4, 32, 0, 0, 0, 0, 0},    // R4: zero-length run appends nothing
    '{24, 40, 23, 9, 0, 0, 0, 0},   // R3: half-bit boundaries
    '{16, 350, 0, 0, 0, 0, 0, 0}    // R8: overlong run -> error
  };

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, rx_line = 1'b1;
  logic [15:0] tmo = 16'd400;
  logic [20:0] word;
  logic        valid, err;
  logic [20:0] last_word = '0;
  int n_chk = 0, n_fail = 0, cyc_total = 0;

  always #2.5 clk = ~clk;

  telem_edge_rx uut (
    .clk(clk), .rst(rst), .start_i(start), .line_i(rx_line),
    .timeout_i(tmo), .word_o(word), .valid_o(valid), .err_o(err));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc_total);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  function automatic void model(input int n, input int gaps[40],
                                output logic [20:0] w, output bit ok);
    int edges = (n + 1 > 32) ? 32 : n + 1;
    int bits = 0;
    int len;
    longint unsigned acc = 0;
    for (int i = 0; i < edges - 1; i++) begin
      if (bits >= 21) break;
      len = (gaps[i] + 8) / 16;
      if (len > 0) begin
        acc = (acc << len) | (64'd1 << (len - 1));
        bits += len;
      end
    end
    if (bits < 21) begin
      len = 21 - bits;
      acc = (acc << len) | (64'd1 << (len - 1));
      bits = 21;
    end
    ok = (bits == 21);
    w = acc[20:0];
  endfunction

  task automatic run_frame(input string tag, input int to, input int n, input int gaps[40]);
    logic [20:0] ew;
    bit eok;
    int waited = 0;
    model(n, gaps, ew, eok);
    tmo = to[15:0];
    start = 1'b1;
    step;
    start = 1'b0;
    repeat (19) step;
    rx_line = ~rx_line;
    for (int i = 0; i < n; i++) begin
      repeat (2 * gaps[i]) step;
      rx_line = ~rx_line;
    end
    while (!valid && !err && waited < 4 * to + 50) begin
      step;
      waited++;
    end
    check({tag, " valid"}, 32'(valid), 32'(eok));
    check({tag, " error"}, 32'(err), 32'(!eok));
    if (eok) last_word = ew;
    check({tag, " word"}, 32'(word), 32'(last_word));
  endtask

  // Cycle-exact window test: start in cycle 0, toggles in listed cycles.
  task automatic win_test(input string tag, input int tw, input int t0, input int t1,
                          input int t2, input int t3, input int restart,
                          input bit eok, input logic [20:0] ew);
    tmo = tw[15:0];
    start = 1'b1;
    step;
    start = 1'b0;
    for (int c = 1; c < 2 * tw + 2; c++) begin
      if (c == 2 * tw + 1) check({tag, " quiet before close R9"}, 32'({valid, err}), 32'd0);
      if (c == t0 || c == t1 || c == t2 || c == t3) rx_line = ~rx_line;
      start = (c == restart);
      step;
    end
    check({tag, " valid"}, 32'(valid), 32'(eok));
    check({tag, " error"}, 32'(err), 32'(!eok));
    if (eok) last_word = ew;
    check({tag, " word"}, 32'(word), 32'(last_word));
    step;
    check({tag, " single-cycle pulse R9"}, 32'({valid, err}), 32'd0);
  endtask

  initial begin
    int g[40];
    int extra;
    repeat (4) step;
    rst = 1'b0;
    step;
    check("R1 reset valid", 32'(valid), 32'd0);
    check("R1 reset error", 32'(err), 32'd0);
    check("R1 reset word", 32'(word), 32'd0);

    for (int v = 0; v < NV; v++) begin
      foreach (g[i]) g[i] = 0;
      for (int j = 0; j < 8; j++) g[j] = VG[v][j];
      run_frame($sformatf("vec%0d", v), 400, VN[v], g);
    end

    // R8 R9: no edges -> error pulse exactly at cycle 2T+2
    win_test("R8 no edges", 100, -1, -1, -1, -1, -1, 1'b0, 21'h0);

    // R7 R5: single edge -> padded to one 21-bit run
    foreach (g[i]) g[i] = 0;
    run_frame("R7 R5 single edge", 100, 0, g);

    // R12: restart inside the window is ignored
    win_test("R12 restart ignored", 100, 30, -1, -1, -1, 50, 1'b1, 21'h100000);
    extra = 0;
    repeat (250) begin
      step;
      if (valid || err) extra++;
    end
    check("R12 no second result", 32'(extra), 32'd0);

    // R10: edge in the closing cycle is consumed; one cycle later is not
    win_test("R10 closing-cycle edge", 100, 36, 196, -1, -1, -1, 1'b1, 21'h108000);
    win_test("R10 late edge ignored", 100, 36, 197, -1, -1, -1, 1'b1, 21'h100000);

    // R2: 3-cycle glitch rejected, 4-cycle pulse accepted
    win_test("R2 glitch rejected", 400, 20, 60, 63, 180, -1, 1'b1, 21'h108000);
    win_test("R2 short pulse kept", 400, 20, 60, 64, 180, -1, 1'b1, 21'h188000);

    // R11: 33 edges, the 33rd must be ignored
    foreach (g[i]) g[i] = 0;
    for (int j = 0; j < 30; j++) g[j] = 4;
    g[30] = 16;
    g[31] = 32;
    run_frame("R11 edge budget", 400, 32, g);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule